// File: doc/BRIEF.md
# Backplane Trigger Line Controller

This block lets one instrument module take part in a bank of eight shared, open-collector trigger lines on a chassis backplane. A line is active when pulled low, and all drivers combine as a wired-OR, so the block reads the real line level back and never assumes that its own drive wins. A single engine handles three protocols. The first is a synchronous broadcast pulse. The second is a two-line handshake between one source and one acceptor. The third is a start/stop level that only the slot-0 controller may drive.

Module logic sets up the block through a small write-only register port: protocol, role, line number and pulse length. It then uses a request strobe and an acknowledge strobe to start or answer a trigger. The block reports trigger events, handshake completion, a busy flag, the decoded start/stop level and a configuration error flag. Everything runs on the 10 MHz chassis system clock. Each incoming line passes through a two-flop synchronizer before any logic uses it.

Top module: `trig_line_ctrl`

## Requirements
- R1: After reset no line is pulled, and `event_o`, `done_o`, `busy_o`, `run_o` and `cfg_err_o` are all low.
- R2: Configuration register 0 holds the protocol in bits [1:0] (00 off, 01 synchronous, 10 handshake, 11 start/stop) and the role in bits [3:2] (00 monitor, 01 source, 10 acceptor, 11 slot-0). Register 1 holds the line number in bits [2:0], and register 2 holds the pulse length. In synchronous mode a source samples `req_i` and pulls the selected line for exactly that many clock cycles, where a length of 0 counts as 1. A request that arrives while the pulse is still running is ignored.
- R3: In synchronous mode, in any role, a falling edge on the selected line raises `event_o` for one cycle. The pulse comes in the cycle that follows the second rising clock edge after the line goes low. The block's own pulse is reported in the same way.
- R4: In handshake mode, a source pulls the even line of the pair (line number with bit 0 cleared) on a request. It holds that line until it sees the odd line of the pair low, then releases it three clock edges after the acknowledge appears and pulses `done_o` for one cycle.
- R5: A handshake source keeps `busy_o` high from its request until both lines of the pair are seen released. Requests made while busy are ignored.
- R6: A handshake acceptor raises `event_o` when the even line falls. It pulls the odd line one cycle after `ack_i`, and releases the odd line only after it sees the even line released.
- R7: In handshake mode an odd line number sets `cfg_err_o`, and the block then drives no line.
- R8: In start/stop mode with the slot-0 role, `req_i` pulls the selected line low (start) and `ack_i` releases it (stop). `run_o` is high while the synchronized line is low.
- R9: In start/stop mode with any other role, the block never drives a line, and `run_o` follows the synchronized level of the selected line.
- R10: The block never pulls more than one line at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz chassis system clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe; also returns the engine to idle |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| req_i | input | 1 | Local request strobe (start in start/stop mode) |
| ack_i | input | 1 | Local acknowledge strobe (stop in start/stop mode) |
| line_n_i | input | 8 | Sensed trigger line levels, low = asserted |
| pull_o | output | 8 | Open-collector pull-down enables, high = pull line low |
| event_o | output | 1 | One-cycle trigger event |
| done_o | output | 1 | One-cycle handshake completion (source) |
| busy_o | output | 1 | Engine busy, new requests ignored |
| run_o | output | 1 | Start/stop level, high = start |
| cfg_err_o | output | 1 | Invalid handshake pair selected |

## Verification
In synchronous mode, the block's own pulse comes back through the synchronizer and produces an event while the pulse is still being driven. A second local request can therefore land in the very cycle the event is raised. The bench makes this happen by pulsing `req_i` in the exact event cycle. It then counts the cycles the line stays pulled and the events the scoreboard receives. A correct design shows exactly the programmed length and a single event, so any retrigger or lost event gets flagged.

// File: rtl/trig_line_ctrl.sv
`timescale 1ns/1ps
module trig_line_ctrl #(
  parameter int NLINES = 8,
  parameter int LENW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic [NLINES-1:0] line_n_i,
  output logic [NLINES-1:0] pull_o,
  output logic              event_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              run_o,
  output logic              cfg_err_o
);
  localparam int SELW = $clog2(NLINES);

  typedef enum logic [1:0] {M_OFF, M_SYNC, M_HSK, M_SS} mode_t;
  typedef enum logic [1:0] {ROLE_MON, ROLE_SRC, ROLE_ACC, ROLE_SLOT0} role_t;
  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_WAIT} src_t;
  typedef enum logic [1:0] {A_IDLE, A_PEND, A_DRIVE} acc_t;

  mode_t            mode_q;
  role_t            role_q;
  logic [SELW-1:0]  sel_q;
  logic [LENW-1:0]  len_q;
  logic [NLINES-1:0] s1_q, s2_q, s2d_q;
  logic [LENW-1:0]  cnt_q;
  src_t             src_q;
  acc_t             acc_q;
  logic             done_q, ss_q;
  logic             unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= M_OFF;
      role_q <= ROLE_MON;
      sel_q  <= '0;
      len_q  <= LENW'(1);
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin
          mode_q <= mode_t'(cfg_wdata[1:0]);
          role_q <= role_t'(cfg_wdata[3:2]);
        end
        2'd1: sel_q <= cfg_wdata[SELW-1:0];
        2'd2: len_q <= cfg_wdata[LENW-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q  <= '1;
      s2_q  <= '1;
      s2d_q <= '1;
    end else begin
      s1_q  <= line_n_i;
      s2_q  <= s1_q;
      s2d_q <= s2_q;
    end

  logic [SELW-1:0] lo_idx, hi_idx;
  logic lo_low, hi_low, lo_fall, sel_fall, hsk_ok;
  logic [LENW-1:0] len_eff;

  assign lo_idx   = {sel_q[SELW-1:1], 1'b0};
  assign hi_idx   = lo_idx | SELW'(1);
  assign lo_low   = ~s2_q[lo_idx];
  assign hi_low   = ~s2_q[hi_idx];
  assign lo_fall  = s2d_q[lo_idx] & ~s2_q[lo_idx];
  assign sel_fall = s2d_q[sel_q] & ~s2_q[sel_q];
  assign hsk_ok   = (mode_q == M_HSK) && !sel_q[0];
  assign len_eff  = (len_q == '0) ? LENW'(1) : len_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt_q <= '0;
    else if (cfg_we)
      cnt_q <= '0;
    else if (mode_q == M_SYNC && role_q == ROLE_SRC && req_i && cnt_q == '0)
      cnt_q <= len_eff;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - LENW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_q  <= S_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we)
        src_q <= S_IDLE;
      else
        case (src_q)
          S_IDLE:  if (hsk_ok && role_q == ROLE_SRC && req_i && !lo_low && !hi_low)
                     src_q <= S_DRIVE;
          S_DRIVE: if (hi_low) begin
                     src_q  <= S_WAIT;
                     done_q <= 1'b1;
                   end
          S_WAIT:  if (!lo_low && !hi_low)
                     src_q <= S_IDLE;
          default: src_q <= S_IDLE;
        endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      acc_q <= A_IDLE;
    else if (cfg_we)
      acc_q <= A_IDLE;
    else
      case (acc_q)
        A_IDLE:  if (hsk_ok && role_q == ROLE_ACC && lo_fall)
                   acc_q <= A_PEND;
        A_PEND:  if (!lo_low)
                   acc_q <= A_IDLE;
                 else if (ack_i)
                   acc_q <= A_DRIVE;
        A_DRIVE: if (!lo_low)
                   acc_q <= A_IDLE;
        default: acc_q <= A_IDLE;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      ss_q <= 1'b0;
    else if (cfg_we)
      ss_q <= 1'b0;
    else if (mode_q == M_SS && role_q == ROLE_SLOT0) begin
      if (req_i)
        ss_q <= 1'b1;
      else if (ack_i)
        ss_q <= 1'b0;
    end

  always_comb begin
    pull_o = '0;
    case (mode_q)
      M_SYNC: if (cnt_q != '0) pull_o[sel_q] = 1'b1;
      M_HSK:  if (hsk_ok) begin
                if (src_q == S_DRIVE) pull_o[lo_idx] = 1'b1;
                if (acc_q == A_DRIVE) pull_o[hi_idx] = 1'b1;
              end
      M_SS:   if (role_q == ROLE_SLOT0 && ss_q) pull_o[sel_q] = 1'b1;
      default: ;
    endcase
  end

  assign event_o   = (mode_q == M_SYNC && sel_fall) ||
                     (hsk_ok && role_q != ROLE_SRC && lo_fall);
  assign done_o    = done_q;
  assign busy_o    = (mode_q == M_SYNC && cnt_q != '0) ||
                     (hsk_ok && role_q == ROLE_SRC && (src_q != S_IDLE || lo_low || hi_low)) ||
                     (hsk_ok && role_q == ROLE_ACC && acc_q != A_IDLE);
  assign run_o     = (mode_q == M_SS) && !s2_q[sel_q];
  assign cfg_err_o = (mode_q == M_HSK) && sel_q[0];

  p_one_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pull_o));

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (pull_o == '0));

  p_listen_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SS && role_q != ROLE_SLOT0) |-> (pull_o == '0));

  p_src_release_r4: assert property (@(posedge clk) disable iff (!rst_n || cfg_we)
    (src_q == S_DRIVE && hi_low) |=> !pull_o[lo_idx]);

  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || cfg_we)
    (acc_q == A_DRIVE && lo_low) |=> pull_o[hi_idx]);

  p_done_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/test_trig_line_ctrl.sv
`timescale 1ns/1ps
module test_trig_line_ctrl;
  localparam int CLK_PERIOD = 100;
  localparam int EVT = 0;
  localparam int DONE = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       req_i = 1'b0;
  logic       ack_i = 1'b0;
  logic [7:0] tb_pull = '0;
  logic [7:0] line_n, pull_o;
  logic       event_o, done_o, busy_o, run_o, cfg_err_o;

  assign line_n = ~(pull_o | tb_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_line_ctrl i_trig_line_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_i(req_i), .ack_i(ack_i), .line_n_i(line_n),
    .pull_o(pull_o), .event_o(event_o), .done_o(done_o), .busy_o(busy_o),
    .run_o(run_o), .cfg_err_o(cfg_err_o));

  int    n_chk = 0, n_fail = 0;
  int    sb_chk = 0, sb_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  int    rd = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic expect_item(input int kind, input string rq);
    exp_q.push_back(kind);
    tag_q.push_back(rq);
  endtask

  task automatic sb_take(input int kind);
    sb_chk++;
    if (rd >= exp_q.size()) begin
      sb_fail++;
      $display("FAIL SB unexpected actual=%0d expected=none", kind);
    end else begin
      if (exp_q[rd] != kind) begin
        sb_fail++;
        $display("FAIL %s actual=%0d expected=%0d", tag_q[rd], kind, exp_q[rd]);
      end
      rd++;
    end
  endtask

  always @(negedge clk)
    if (rst_n) begin
      if (event_o) sb_take(EVT);
      if (done_o)  sb_take(DONE);
    end

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strobe_req;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic sync_pulse(input int len, input string rq, input bit retrig);
    int cnt = 0;
    bit stray = 1'b0;
    expect_item(EVT, "R3");
    @(negedge clk);
    req_i = 1'b1;
    for (int i = 0; i < len + 8; i++) begin
      @(negedge clk);
      req_i = (retrig && i == 2) ? 1'b1 : 1'b0;
      if (pull_o[1]) cnt++;
      if ((pull_o & 8'hFD) != 0) stray = 1'b1;
    end
    chk(cnt == len, rq, cnt, len);
    chk(!stray, "R10", int'(stray), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk + sb_chk + 1, n_fail + sb_fail + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pull_o == 0 && !busy_o && !event_o && !done_o && !run_o && !cfg_err_o, "R1",
        {pull_o, busy_o, event_o, done_o, run_o, cfg_err_o}, 0);

    // R2/R3: synchronous source on line 1, retrigger in the event cycle
    cfg(2'd2, 8'd5);
    cfg(2'd1, 8'd1);
    cfg(2'd0, 8'b0000_0101);
    sync_pulse(5, "R2", 1'b1);
    cfg(2'd2, 8'd0);
    sync_pulse(1, "R2", 1'b0);

    // R3: monitor latency on line 3
    cfg(2'd1, 8'd3);
    cfg(2'd0, 8'b0000_0001);
    expect_item(EVT, "R3");
    @(negedge clk);
    tb_pull[3] = 1'b1;
    @(negedge clk); chk(!event_o, "R3", int'(event_o), 0);
    @(negedge clk); chk(event_o,  "R3", int'(event_o), 1);
    @(negedge clk); chk(!event_o, "R3", int'(event_o), 0);
    chk(pull_o == 0, "R3", pull_o, 0);
    tb_pull[3] = 1'b0;
    repeat (4) @(negedge clk);

    // R4/R5: handshake source on pair 2-3
    cfg(2'd1, 8'd2);
    cfg(2'd0, 8'b0000_0110);
    chk(!cfg_err_o, "R7", int'(cfg_err_o), 0);
    @(negedge clk);
    strobe_req();
    chk(pull_o == 8'h04, "R4", pull_o, 8'h04);
    chk(busy_o, "R5", int'(busy_o), 1);
    repeat (3) @(negedge clk);
    chk(pull_o == 8'h04, "R4", pull_o, 8'h04);
    expect_item(DONE, "R4");
    tb_pull[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); chk(pull_o == 8'h04, "R4", pull_o, 8'h04);
    @(negedge clk); chk(pull_o == 8'h00, "R4", pull_o, 0);
    chk(busy_o, "R5", int'(busy_o), 1);
    strobe_req();
    chk(pull_o == 8'h00, "R5", pull_o, 0);
    tb_pull[3] = 1'b0;
    @(negedge clk); chk(busy_o, "R5", int'(busy_o), 1);
    repeat (3) @(negedge clk);
    chk(!busy_o, "R5", int'(busy_o), 0);

    // R6: handshake acceptor on pair 4-5
    cfg(2'd1, 8'd4);
    cfg(2'd0, 8'b0000_1010);
    expect_item(EVT, "R6");
    @(negedge clk);
    tb_pull[4] = 1'b1;
    repeat (4) @(negedge clk);
    chk(pull_o == 8'h00, "R6", pull_o, 0);
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    chk(pull_o == 8'h20, "R6", pull_o, 8'h20);
    tb_pull[4] = 1'b0;
    @(negedge clk); chk(pull_o == 8'h20, "R6", pull_o, 8'h20);
    repeat (3) @(negedge clk);
    chk(pull_o == 8'h00, "R6", pull_o, 0);

    // R7: odd base line
    cfg(2'd1, 8'd5);
    cfg(2'd0, 8'b0000_0110);
    chk(cfg_err_o, "R7", int'(cfg_err_o), 1);
    strobe_req();
    repeat (2) @(negedge clk);
    chk(pull_o == 8'h00, "R7", pull_o, 0);

    // R8: start/stop as slot-0 on line 6
    cfg(2'd1, 8'd6);
    cfg(2'd0, 8'b0000_1111);
    chk(!cfg_err_o, "R8", int'(cfg_err_o), 0);
    strobe_req();
    chk(pull_o == 8'h40, "R8", pull_o, 8'h40);
    repeat (2) @(negedge clk);
    chk(run_o, "R8", int'(run_o), 1);
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    chk(pull_o == 8'h00, "R8", pull_o, 0);
    repeat (3) @(negedge clk);
    chk(!run_o, "R8", int'(run_o), 0);

    // R9: start/stop listener on line 7
    cfg(2'd1, 8'd7);
    cfg(2'd0, 8'b0000_0011);
    strobe_req();
    @(negedge clk);
    chk(pull_o == 8'h00, "R9", pull_o, 0);
    tb_pull[7] = 1'b1;
    repeat (3) @(negedge clk);
    chk(run_o && pull_o == 0, "R9", {pull_o, run_o}, 1);
    tb_pull[7] = 1'b0;
    repeat (3) @(negedge clk);
    chk(!run_o, "R9", int'(run_o), 0);

    repeat (4) @(negedge clk);
    chk(rd == exp_q.size(), "R3", rd, exp_q.size());
    $display("[TB] %0d tests run, %0d failed", n_chk + sb_chk, n_fail + sb_fail);
    $finish;
  end
endmodule